// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor core that finishes each instruction in the clock cycle in which it is fetched. It implements eight instructions: five register-to-register arithmetic and logic operations (add, sub, and, or, set-on-less-than), a word load, a word store and a branch-if-equal. Instruction and data storage sit outside the core on two separate ports. The instruction port is read-only. The data port has a read strobe and a write strobe. Both memories are 32 bits wide and byte addressed, so the surrounding logic selects a word with address bits [31:2].

Inside the core are the program counter, a 32-entry register file, an ALU, a sign extender, the branch-target adder, the datapath selects and a purely combinational decoder. The decoder reads the opcode and the function field. An instruction that the decoder does not recognise changes neither the registers nor the data memory. Each instruction is fetched, decoded and executed in one cycle. Its register or memory write lands on the next rising clock edge.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the program counter becomes 0, so `imem_addr` reads 0 after that edge.
- R2: For every instruction except a taken branch, `imem_addr` advances by 4 at each clock edge, and it is always word aligned.
- R3: Opcode 000000 with shamt bits [10:6] equal to 0 selects an R-type operation by its function code in bits [5:0]: 100000 add, 100010 sub, 100100 and, 100101 or, 101010 set-on-less-than. The result is written to the register named by bits [15:11]. Set-on-less-than compares the operands as signed two's-complement values and writes 1 or 0.
- R4: A load (opcode 100011) drives `dmem_addr` with the sum of the base register in bits [25:21] and the sign-extended constant in bits [15:0]. It raises `dmem_rd` and writes `dmem_rdata` to the register named by bits [20:16]. Negative constants are accepted.
- R5: A store (opcode 101011) raises `dmem_wr` and drives `dmem_addr` with the base register plus the sign-extended constant. It drives `dmem_wdata` with the register named by bits [20:16].
- R6: A branch (opcode 000100) whose two source registers are equal loads PC+4+(sign-extended offset × 4). An unequal pair continues at PC+4. Offsets may be negative.
- R7: Register 0 always reads as zero, and writes to it are discarded.
- R8: An unknown opcode, an unknown R-type function code, or an R-type word with a nonzero shamt field writes neither a register nor the data memory.
- R9: `dmem_rd` is high only for a load and `dmem_wr` only for a store. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | 32 | Byte address of the current instruction (program counter) |
| imem_data | input | 32 | Instruction word at `imem_addr`, combinational |
| dmem_addr | output | 32 | Byte address for a load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_rdata | input | 32 | Load data at `dmem_addr`, combinational |
| dmem_rd | output | 1 | Data memory read strobe |
| dmem_wr | output | 1 | Data memory write strobe, taken on the next rising edge |

## Verification
The assertions assume that `imem_data` always holds a fully defined word for the current `imem_addr` and that `dmem_rdata` settles within the same cycle. The bench keeps to this with instruction and data arrays that are completely initialised and read combinationally. Every address it generates falls inside those arrays. It changes `rst_n` only on the falling edge, and it reloads data memory only while reset is held and the fetched word is a load. The stimulus therefore never puts an undefined instruction or a half-settled operand in front of the decoder.

// File: rtl/sc_core_pkg.sv
// Package: shared encodings and the control word of the single-cycle core.
// Assumes the fixed 32-bit instruction layout; data width is set by the core.
package sc_core_pkg;

    localparam int unsigned INSN_W = 32;
    localparam int unsigned REG_AW = 5;
    localparam int unsigned NREGS  = 1 << REG_AW;
    localparam int unsigned IMM_W  = 16;

    // Opcodes in bits [31:26]
    localparam logic [5:0] OPC_RTYPE = 6'b000000;
    localparam logic [5:0] OPC_LOAD  = 6'b100011;
    localparam logic [5:0] OPC_STORE = 6'b101011;
    localparam logic [5:0] OPC_BEQ   = 6'b000100;

    // R-type function codes in bits [5:0]
    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_SLT = 6'b101010;

    // ALU select codes
    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_sel_e;

    // Control word from the decoder
    typedef struct packed {
        logic     dst_is_rd;    // write address from rd (1) or rt (0)
        logic     reg_we;       // register file write enable
        logic     opb_imm;      // second ALU operand is the constant
        alu_sel_e alu_sel;      // ALU function
        logic     mem_we;       // data memory write strobe
        logic     mem_re;       // data memory read strobe
        logic     wb_from_mem;  // write-back data from memory
        logic     branch;       // conditional branch on equality
    } ctrl_t;

endpackage

// File: rtl/sc_core_decode.sv
// Module: combinational instruction decoder.
// Maps opcode, function and shamt fields to one control word. Anything
// unrecognised yields a word with every write enable low.
module sc_core_decode
    import sc_core_pkg::*;
(
    input  logic [5:0] op,
    input  logic [5:0] func,
    input  logic [4:0] shamt,
    output ctrl_t      ctrl
);

    // Purpose: pick the ALU function of a valid R-type word
    logic     r_ok;
    alu_sel_e r_sel;
    always_comb begin
        r_ok  = (shamt == '0);
        r_sel = ALU_ADD;
        case (func)
            FN_ADD:  r_sel = ALU_ADD;
            FN_SUB:  r_sel = ALU_SUB;
            FN_AND:  r_sel = ALU_AND;
            FN_OR:   r_sel = ALU_OR;
            FN_SLT:  r_sel = ALU_SLT;
            default: r_ok  = 1'b0;
        endcase
    end

    // Purpose: build the control word from the opcode
    always_comb begin
        ctrl         = '0;
        ctrl.alu_sel = ALU_ADD;
        case (op)
            OPC_RTYPE: begin
                ctrl.dst_is_rd = 1'b1;
                ctrl.reg_we    = r_ok;
                ctrl.alu_sel   = r_sel;
            end
            OPC_LOAD: begin
                ctrl.reg_we      = 1'b1;
                ctrl.opb_imm     = 1'b1;
                ctrl.mem_re      = 1'b1;
                ctrl.wb_from_mem = 1'b1;
            end
            OPC_STORE: begin
                ctrl.opb_imm = 1'b1;
                ctrl.mem_we  = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.alu_sel = ALU_SUB;
                ctrl.branch  = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sc_core_alu.sv
// Module: five-function ALU with a zero flag.
// Assumes two's-complement operands; set-on-less-than is a signed compare.
module sc_core_alu
    import sc_core_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  alu_sel_e          sel,
    output logic [DATA_W-1:0] res,
    output logic              zero
);

    // Purpose: compute the selected function
    always_comb begin
        case (sel)
            ALU_AND: res = opa & opb;
            ALU_OR:  res = opa | opb;
            ALU_ADD: res = opa + opb;
            ALU_SUB: res = opa - opb;
            ALU_SLT: res = {{(DATA_W-1){1'b0}}, ($signed(opa) < $signed(opb))};
            default: res = opa + opb;
        endcase
    end

    // Purpose: flag an all-zero result for the branch compare
    always_comb zero = (res == '0);

endmodule

// File: rtl/sc_core_regs.sv
// Module: register file, two combinational read ports and one write port.
// Entry 0 is a constant zero. Writes land on the rising edge; a synchronous
// active-low reset clears every entry.
module sc_core_regs
    import sc_core_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] ra_a,
    input  logic [REG_AW-1:0] ra_b,
    output logic [DATA_W-1:0] rd_a,
    output logic [DATA_W-1:0] rd_b,
    input  logic              we,
    input  logic [REG_AW-1:0] wa,
    input  logic [DATA_W-1:0] wd
);

    logic [DATA_W-1:0] regs [NREGS];

    for (genvar i = 0; i < NREGS; i++) begin : g_reg
        if (i == 0) begin : g_zero
            assign regs[i] = '0;
        end else begin : g_flop
            // Purpose: hold entry i, updated when addressed
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs[i] <= '0;
                else if (we && (wa == REG_AW'(i)))
                    regs[i] <= wd;
            end
        end
    end

    // Purpose: combinational read ports
    always_comb begin
        rd_a = regs[ra_a];
        rd_b = regs[ra_b];
    end

endmodule

// File: rtl/sc_core.sv
// Module: single-cycle load/store processor core (top).
// Fetch, decode, execute, memory access and write-back all happen in one
// cycle. The memories are external and read combinationally. rst_n is
// synchronous and active low and clears the program counter and registers.
module sc_core
    import sc_core_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [DATA_W-1:0] imem_addr,
    input  logic [INSN_W-1:0] imem_data,
    output logic [DATA_W-1:0] dmem_addr,
    output logic [DATA_W-1:0] dmem_wdata,
    input  logic [DATA_W-1:0] dmem_rdata,
    output logic              dmem_rd,
    output logic              dmem_wr
);

    localparam int unsigned EXT_W = DATA_W - IMM_W;

    // Instruction fields
    logic [5:0]        f_op, f_fn;
    logic [REG_AW-1:0] f_rs, f_rt, f_rd;
    logic [4:0]        f_sh;
    logic [IMM_W-1:0]  f_imm;

    // Purpose: slice the instruction word
    always_comb begin
        f_op  = imem_data[31:26];
        f_rs  = imem_data[25:21];
        f_rt  = imem_data[20:16];
        f_rd  = imem_data[15:11];
        f_sh  = imem_data[10:6];
        f_fn  = imem_data[5:0];
        f_imm = imem_data[15:0];
    end

    ctrl_t ctrl;

    sc_core_decode i_decode (
        .op    (f_op),
        .func  (f_fn),
        .shamt (f_sh),
        .ctrl  (ctrl)
    );

    logic [DATA_W-1:0] src_a, src_b, wb_data, imm_ext, opb, alu_res;
    logic [REG_AW-1:0] wb_addr;
    logic              alu_zero;

    sc_core_regs #(.DATA_W(DATA_W)) i_regs (
        .clk  (clk),
        .rst_n(rst_n),
        .ra_a (f_rs),
        .ra_b (f_rt),
        .rd_a (src_a),
        .rd_b (src_b),
        .we   (ctrl.reg_we),
        .wa   (wb_addr),
        .wd   (wb_data)
    );

    // Purpose: sign extension and operand/destination selects
    always_comb begin
        imm_ext = {{EXT_W{f_imm[IMM_W-1]}}, f_imm};
        opb     = ctrl.opb_imm ? imm_ext : src_b;
        wb_addr = ctrl.dst_is_rd ? f_rd : f_rt;
    end

    sc_core_alu #(.DATA_W(DATA_W)) i_alu (
        .opa  (src_a),
        .opb  (opb),
        .sel  (ctrl.alu_sel),
        .res  (alu_res),
        .zero (alu_zero)
    );

    // Purpose: write-back source select
    always_comb wb_data = ctrl.wb_from_mem ? dmem_rdata : alu_res;

    // Purpose: data memory port
    always_comb begin
        dmem_addr  = alu_res;
        dmem_wdata = src_b;
        dmem_rd    = ctrl.mem_re;
        dmem_wr    = ctrl.mem_we;
    end

    // Program counter
    logic [DATA_W-1:0] pc_q, pc_seq, pc_tgt, pc_next;
    logic              take_br;

    // Purpose: next-PC computation
    always_comb begin
        pc_seq  = pc_q + DATA_W'(4);
        pc_tgt  = pc_seq + {imm_ext[DATA_W-3:0], 2'b00};
        take_br = ctrl.branch & alu_zero;
        pc_next = take_br ? pc_tgt : pc_seq;
    end

    // Purpose: program counter register
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc_q <= '0;
        else
            pc_q <= pc_next;
    end

    always_comb imem_addr = pc_q;

endmodule

// File: rtl/sc_core_chk.sv
// Module: port-level checker for sc_core, attached by bind below.
// Assumes imem_data is fully defined for the current imem_addr.
module sc_core_chk
    import sc_core_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] imem_addr,
    input logic [INSN_W-1:0] imem_data,
    input logic              dmem_rd,
    input logic              dmem_wr
);

    localparam int unsigned EXT_W = DATA_W - IMM_W;

    logic [5:0]        op;
    logic [DATA_W-1:0] br_off;
    logic              known_op;

    // Purpose: decode the fields the properties refer to
    always_comb begin
        op       = imem_data[31:26];
        br_off   = {{EXT_W{imem_data[15]}}, imem_data[15:0]};
        known_op = (op == OPC_RTYPE) || (op == OPC_LOAD) ||
                   (op == OPC_STORE) || (op == OPC_BEQ);
    end

    // R2: sequential advance for anything that is not a branch
    assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op != OPC_BEQ) |=> (imem_addr == $past(imem_addr) + DATA_W'(4)));

    // R2: fetch address stays word aligned
    assert_pc_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        imem_addr[1:0] == 2'b00);

    // R6: a branch lands on either the fall-through or the target
    assert_branch_dest_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OPC_BEQ) |=>
            ((imem_addr == $past(imem_addr) + DATA_W'(4)) ||
             (imem_addr == $past(imem_addr) + DATA_W'(4) + {$past(br_off[DATA_W-3:0]), 2'b00})));

    // R9: strobes are exclusive
    assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(dmem_rd && dmem_wr));

    // R5: write strobe only for a store
    assert_wr_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_wr |-> (op == OPC_STORE));

    // R4: read strobe only for a load
    assert_rd_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_rd |-> (op == OPC_LOAD));

    // R8: unknown opcode touches no memory
    assert_unknown_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !known_op |-> (!dmem_wr && !dmem_rd));

endmodule

bind sc_core sc_core_chk #(.DATA_W(DATA_W)) i_sc_core_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .imem_addr (imem_addr),
    .imem_data (imem_data),
    .dmem_rd   (dmem_rd),
    .dmem_wr   (dmem_wr)
);

// File: tb/test_sc_core.sv
`timescale 1ns/1ps
// Bench: sweeps every pair from a set of operand values through one program
// that exercises each instruction, then compares data memory and ports
// against values computed here.
module test_sc_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_rd, dmem_wr;

    always #2.5 clk = ~clk;

    sc_core i_sc_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .imem_addr (imem_addr),
        .imem_data (imem_data),
        .dmem_addr (dmem_addr),
        .dmem_wdata(dmem_wdata),
        .dmem_rdata(dmem_rdata),
        .dmem_rd   (dmem_rd),
        .dmem_wr   (dmem_wr)
    );

    logic [31:0] imem [64];
    logic [31:0] dmem [64];

    assign imem_data  = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];

    always @(posedge clk) if (dmem_wr) dmem[dmem_addr[7:2]] <= dmem_wdata;

    localparam logic [31:0] SENT = 32'hDEAD_BEEF;
    localparam logic [31:0] MAGIC = 32'h1234_5678;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rins(input int rs, input int rt, input int rd,
                                         input logic [5:0] fn, input logic [4:0] sh);
        return {6'b000000, rs[4:0], rt[4:0], rd[4:0], sh, fn};
    endfunction

    function automatic logic [31:0] iins(input logic [5:0] op, input int rs, input int rt, input int imm);
        return {op, rs[4:0], rt[4:0], imm[15:0]};
    endfunction

    localparam logic [5:0] LW = 6'b100011, SW = 6'b101011, BEQ = 6'b000100;

    task automatic load_program();
        for (int i = 0; i < 64; i++) imem[i] = iins(BEQ, 0, 0, -1);
        imem[0]  = iins(LW, 0, 1, 0);
        imem[1]  = iins(LW, 0, 2, 4);
        imem[2]  = rins(1, 2, 3, 6'b100000, 5'd0);   // add
        imem[3]  = iins(SW, 0, 3, 8);
        imem[4]  = rins(1, 2, 3, 6'b100010, 5'd0);   // sub
        imem[5]  = iins(SW, 0, 3, 12);
        imem[6]  = rins(1, 2, 3, 6'b100100, 5'd0);   // and
        imem[7]  = iins(SW, 0, 3, 16);
        imem[8]  = rins(1, 2, 3, 6'b100101, 5'd0);   // or
        imem[9]  = iins(SW, 0, 3, 20);
        imem[10] = rins(1, 2, 3, 6'b101010, 5'd0);   // slt
        imem[11] = iins(SW, 0, 3, 24);
        imem[12] = iins(BEQ, 1, 2, 1);               // skip next when equal
        imem[13] = iins(SW, 0, 1, 28);
        imem[14] = iins(SW, 0, 2, 32);
        imem[15] = iins(LW, 0, 5, 0);                // r5 = a
        imem[16] = rins(1, 2, 5, 6'b000000, 5'd0);   // unknown func
        imem[17] = rins(1, 2, 5, 6'b100000, 5'd3);   // add with shamt set
        imem[18] = iins(SW, 0, 5, 44);
        imem[19] = iins(6'b001000, 1, 5, 7);         // unknown opcode
        imem[20] = iins(SW, 0, 5, 48);
        imem[21] = rins(1, 2, 0, 6'b100101, 5'd0);   // or into r0
        imem[22] = iins(SW, 0, 0, 40);
        imem[23] = iins(LW, 0, 6, 36);               // r6 = 64
        imem[24] = iins(LW, 6, 7, -4);               // word 15
        imem[25] = iins(SW, 6, 7, -8);               // word 14
        imem[26] = iins(BEQ, 0, 0, -1);              // halt at 104
    endtask

    task automatic run_pair(input logic [31:0] a, input logic [31:0] b, input bit first);
        logic [31:0] exp_or;
        int stray;
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < 64; i++) dmem[i] = SENT;
        dmem[0] = a; dmem[1] = b; dmem[9] = 32'd64; dmem[15] = MAGIC;
        if (first) check("R1 pc after reset", imem_addr, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        #0.5;
        check("R9 load read strobe", {31'd0, dmem_rd}, 32'd1);
        check("R4 load address", dmem_addr, 32'd0);
        @(negedge clk);
        check("R2 pc step", imem_addr, 32'd4);
        @(negedge clk); @(negedge clk);
        check("R5 store strobes", {30'd0, dmem_wr, dmem_rd}, 32'd2);
        check("R5 store addr", dmem_addr, 32'd8);
        check("R5 store data", dmem_wdata, a + b);
        repeat (40) @(negedge clk);
        exp_or = a | b;
        check("R3 add", dmem[2], a + b);
        check("R3 sub", dmem[3], a - b);
        check("R3 and", dmem[4], a & b);
        check("R3 or", dmem[5], exp_or);
        check("R3 slt", dmem[6], ($signed(a) < $signed(b)) ? 32'd1 : 32'd0);
        check("R6 forward branch", dmem[7], (a == b) ? SENT : a);
        check("R6 post-branch store", dmem[8], b);
        check("R7 r0 reads zero", dmem[10], 32'd0);
        check("R8 bad func/shamt", dmem[11], a);
        check("R8 bad opcode", dmem[12], a);
        check("R4 negative offset", dmem[14], MAGIC);
        check("R6 backward branch halt", imem_addr, 32'd104);
        stray = 0;
        for (int i = 16; i < 64; i++) if (dmem[i] !== SENT) stray++;
        check("R8 no stray writes", 32'(stray), 32'd0);
    endtask

    localparam logic [31:0] VALS [8] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
                                        32'h8000_0000, 32'h5, 32'hFFFF_FFFB, 32'h1234_5678};

    initial begin
        load_program();
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++)
                run_pair(VALS[i], VALS[j], (i == 0) && (j == 0));
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule